// File: doc/BRIEF.md
# Secured configuration access controller

This block guards the configuration store of a programmable logic core. A host drives single commands over a valid/ready channel. Each accepted command produces one response that carries a status code and a read data word. The block holds four things: a word-addressed configuration array, a 64-bit user signature kept as eight bytes, a sticky security bit, and the bank of output registers that the core would drive. The preload command can force any one of those registers to 0 or 1 for test sequencing.

Setting the security bit takes effect at the clock edge that accepts the command. From then on, configuration readback and register preload are refused with a denied status and have no side effects. Signature reads and writes keep working whatever the security bit holds. Programming stays allowed, but its results can no longer be seen. Only the full-erase command clears the security bit. That command also zeroes the configuration array and leaves the signature untouched.

Top module: `cfg_guard`

## Requirements
- R1: `cmd_ready` is low exactly while `rsp_valid` is high. A command accepted at a clock edge raises `rsp_valid` at that same edge. The response then holds its status and data unchanged until a cycle with `rsp_ready` high clears it.
- R2: Opcode 0 (program) stores `cmd_wdata` at configuration word `cmd_addr` and responds with status 0 (OK). This holds whatever the security bit holds.
- R3: Opcode 1 (readback), with security clear, responds OK with the configuration word at `cmd_addr`.
- R4: Opcode 1 with security set responds with status 1 (denied) and `rsp_rdata` all zeros.
- R5: Opcode 2 (preload), with security clear, sets output register `cmd_addr[2:0]` of `preg_q` to `cmd_wdata[0]`. It leaves every other register unchanged and responds OK.
- R6: Opcode 2 with security set responds denied and leaves `preg_q` unchanged.
- R7: Opcode 4 writes `cmd_wdata[7:0]` to signature byte `cmd_addr[2:0]`. Opcode 3 reads that byte back. Both respond OK whether or not security is set.
- R8: Opcode 5 sets the security bit at the edge that accepts it and responds OK. The very next command already sees the lockout.
- R9: Opcode 6 (erase) clears the security bit and every configuration word, keeps the signature, and responds OK.
- R10: Opcode 7 responds with status 2 (bad command) and changes no state.
- R11: After reset, `rsp_valid` is low, `cmd_ready` is high, `preg_q` is all zeros, security is clear, and both the configuration array and the signature read as zero.
- R12: Every response other than an allowed readback or a signature read carries `rsp_rdata` of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | AW | Word, register or signature byte index |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Host takes the response |
| rsp_status | output | 2 | 0 OK, 1 denied, 2 bad command |
| rsp_rdata | output | DW | Read data, zero when nothing may be returned |
| preg_q | output | NREG | Output register bank, preload target |

## Verification
The assertions assume that the host holds `cmd_valid` low during reset. They also assume the host never offers a command while a response is still pending, which the ready signal makes plain. The stimulus keeps to both: it drives commands only after the previous response has been taken, and it holds `rsp_ready` back for a random zero to two cycles so that response holding is exercised. Random opcodes include the secure and erase commands, so the security bit toggles many times and every command meets both states. A directed sequence covers the first lockout, the immediate effect of securing, and erase recovery.

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_status,
  output logic [DW-1:0]   rsp_rdata,
  output logic [NREG-1:0] preg_q
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = (NREG > 1) ? $clog2(NREG) : 1;

  localparam logic [2:0] OP_PROG = 3'd0, OP_READ = 3'd1, OP_PRELOAD = 3'd2,
                         OP_SIG_RD = 3'd3, OP_SIG_WR = 3'd4, OP_SECURE = 3'd5,
                         OP_ERASE = 3'd6;
  localparam logic [1:0] ST_OK = 2'd0, ST_DENIED = 2'd1, ST_BADCMD = 2'd2;

  logic [DW-1:0] cfg_mem [DEPTH];
  logic [7:0]    sig_mem [8];
  logic          sec_q;
  logic [1:0]    status_d;
  logic [DW-1:0] rdata_d;
  logic          accept;
  logic [PW-1:0] pidx;

  assign cmd_ready = !rsp_valid;
  assign accept    = cmd_valid && cmd_ready;
  assign pidx      = cmd_addr[PW-1:0];

  always_comb begin
    status_d = ST_OK;
    rdata_d  = '0;
    case (cmd_op)
      OP_READ:
        if (sec_q) status_d = ST_DENIED;
        else       rdata_d  = cfg_mem[cmd_addr];
      OP_PRELOAD:
        if (sec_q) status_d = ST_DENIED;
      OP_SIG_RD:
        rdata_d = DW'(sig_mem[cmd_addr[2:0]]);
      OP_PROG, OP_SIG_WR, OP_SECURE, OP_ERASE: ;
      default:
        status_d = ST_BADCMD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
      sec_q      <= 1'b0;
      preg_q     <= '0;
      for (int i = 0; i < DEPTH; i++) cfg_mem[i] <= '0;
      for (int j = 0; j < 8; j++)     sig_mem[j] <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept) begin
        rsp_valid  <= 1'b1;
        rsp_status <= status_d;
        rsp_rdata  <= rdata_d;
        case (cmd_op)
          OP_PROG:    cfg_mem[cmd_addr] <= cmd_wdata;
          OP_PRELOAD: if (!sec_q) preg_q[pidx] <= cmd_wdata[0];
          OP_SIG_WR:  sig_mem[cmd_addr[2:0]] <= cmd_wdata[7:0];
          OP_SECURE:  sec_q <= 1'b1;
          OP_ERASE: begin
            sec_q <= 1'b0;
            for (int k = 0; k < DEPTH; k++) cfg_mem[k] <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module cfg_guard_chk #(
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [1:0]      rsp_status,
  input logic [DW-1:0]   rsp_rdata,
  input logic [NREG-1:0] preg_q,
  input logic            sec_q
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R1
  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata))); // R1
  AST_DENIED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> (rsp_rdata == '0)); // R4
  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sec_q && cmd_op == 3'd1) |=> (rsp_status == 2'd1)); // R4
  AST_LOCKED_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sec_q && cmd_op == 3'd2) |=> (rsp_status == 2'd1 && $stable(preg_q))); // R6
  AST_SIG_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == 3'd3 || cmd_op == 3'd4)) |=> (rsp_status == 2'd0)); // R7
  AST_SECURE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q && !(acc && cmd_op == 3'd6)) |=> sec_q); // R8
  AST_BADCMD_NO_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd7) |=> (rsp_status == 2'd2 && $stable(preg_q))); // R10
endmodule

bind cfg_guard cfg_guard_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .preg_q(preg_q), .sec_q(sec_q)
);

// File: tb/cfg_guard_bench.sv
module cfg_guard_bench;
  localparam int DW = 8, AW = 4, NREG = 8, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid;
  logic [1:0] rsp_status;
  logic [DW-1:0] rsp_rdata;
  logic [NREG-1:0] preg_q;

  int checks = 0, errors = 0;

  logic [DW-1:0]   m_cfg [DEPTH];
  logic [7:0]      m_sig [8];
  logic            m_sec;
  logic [NREG-1:0] m_preg;

  always #5 clk = ~clk;

  cfg_guard #(.DW(DW), .AW(AW), .NREG(NREG)) u_cfg_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .preg_q(preg_q));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic sec);
    case (op)
      3'd0: return "R2";
      3'd1: return sec ? "R4" : "R3";
      3'd2: return sec ? "R6" : "R5";
      3'd3, 3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int hold);
    logic [1:0] e_st;
    logic [DW-1:0] e_rd;
    string t;
    t = tag_of(op, m_sec);
    e_st = 2'd0;
    e_rd = '0;
    case (op)
      3'd0: m_cfg[a] = d;
      3'd1: if (m_sec) e_st = 2'd1; else e_rd = m_cfg[a];
      3'd2: if (m_sec) e_st = 2'd1; else m_preg[a[2:0]] = d[0];
      3'd3: e_rd = m_sig[a[2:0]];
      3'd4: m_sig[a[2:0]] = d;
      3'd5: m_sec = 1'b1;
      3'd6: begin m_sec = 1'b0; for (int i = 0; i < DEPTH; i++) m_cfg[i] = '0; end
      default: e_st = 2'd2;
    endcase
    @(negedge clk);
    check("R1 ready before command", {31'd0, cmd_ready}, 32'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 response raised", {31'd0, rsp_valid}, 32'd1);
    check("R1 ready low while pending", {31'd0, cmd_ready}, 32'd0);
    check({t, " status"}, {30'd0, rsp_status}, {30'd0, e_st});
    check({t, " R12 rdata"}, {24'd0, rsp_rdata}, {24'd0, e_rd});
    check({t, " preg"}, {24'd0, preg_q}, {24'd0, m_preg});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R1 held response", {22'd0, rsp_valid, rsp_status, rsp_rdata},
            {22'd0, 1'b1, e_st, e_rd});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R1 response cleared", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_cfg[i] = '0;
    for (int j = 0; j < 8; j++) m_sig[j] = '0;
    m_sec = 1'b0;
    m_preg = '0;
    repeat (3) @(negedge clk);
    check("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R11 preg", {24'd0, preg_q}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 cmd_ready", {31'd0, cmd_ready}, 32'd1);
    do_cmd(3'd1, 4'd9, 8'h00, 0);   // R11 config zero
    do_cmd(3'd3, 4'd5, 8'h00, 0);   // R11 signature zero
    do_cmd(3'd0, 4'd3, 8'hA5, 0);
    do_cmd(3'd0, 4'd15, 8'h3C, 1);
    do_cmd(3'd1, 4'd3, 8'h00, 2);
    do_cmd(3'd1, 4'd15, 8'h00, 0);
    do_cmd(3'd2, 4'd7, 8'h01, 0);
    do_cmd(3'd2, 4'd0, 8'hFF, 0);
    do_cmd(3'd2, 4'd7, 8'h00, 0);
    do_cmd(3'd4, 4'd2, 8'h5A, 0);
    do_cmd(3'd3, 4'd2, 8'h00, 0);
    do_cmd(3'd7, 4'd3, 8'hFF, 0);
    do_cmd(3'd1, 4'd3, 8'h00, 0);   // R10 no side effect on config
    do_cmd(3'd5, 4'd0, 8'h00, 0);
    do_cmd(3'd1, 4'd3, 8'h00, 1);   // R8 immediate lockout
    do_cmd(3'd2, 4'd0, 8'h00, 0);
    do_cmd(3'd2, 4'd5, 8'h01, 0);
    do_cmd(3'd3, 4'd2, 8'h00, 0);
    do_cmd(3'd4, 4'd6, 8'hC3, 0);
    do_cmd(3'd3, 4'd6, 8'h00, 0);
    do_cmd(3'd0, 4'd4, 8'h77, 0);
    do_cmd(3'd5, 4'd0, 8'h00, 0);
    do_cmd(3'd6, 4'd0, 8'h00, 0);
    do_cmd(3'd1, 4'd3, 8'h00, 0);   // R9 cleared array
    do_cmd(3'd1, 4'd4, 8'h00, 0);
    do_cmd(3'd3, 4'd6, 8'h00, 0);   // R9 signature kept
    do_cmd(3'd2, 4'd5, 8'h01, 0);
    for (int n = 0; n < 600; n++) begin
      do_cmd(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
             8'($urandom), int'($urandom_range(0, 2)));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule